// File: doc/BRIEF.md
# Cache Reconfiguration Sequencer

This block drives the guarded procedure a processor core follows before and after the memory-type range registers are rewritten. On a start request it acquires a lock, switches the cache into no-fill mode, writes back and invalidates the caches, and (where the core supports global pages) saves the control value and then clears its global-page enable. It then invalidates the TLBs, reads and saves the default-type register, and writes that register back with its enable and type fields cleared. A second cache write-back follows. At that point it hands control to an external updater and waits for that agent to report completion.

The exit phase runs the same steps in reverse. It invalidates the TLBs without touching the caches, writes the saved default-type copy back, and clears cache-disable. It then writes back the saved global-page enable and releases the lock. While the updater holds control it may overwrite the saved default-type copy, and the exit phase restores whatever the copy holds at that time. Every external operation is a request held until its acknowledge. An operation that stays unanswered too long raises an error flag, and the sequence keeps waiting. Interrupts are held masked for the whole run.

Top module: `cache_reconfig_seq`

## Requirements
- R1: During and directly after reset the block is idle: busy_o, irq_mask_o, done_o, err_o, upd_go_o and every request output are 0.
- R2: A start_i seen high at a clock edge while idle makes busy_o, irq_mask_o and lock_req_o (with lock_take_o=1, meaning acquire) high in the cycle that follows.
- R3: With global pages supported, the entry operations run in this order: lock acquire, control write with cr_cd_o=1, cache write-back, global-page read (pge_wr_o=0), global-page write (pge_wr_o=1), TLB flush, default-type read (dt_wr_o=0), default-type write, cache write-back, then the updater hand-off (upd_go_o high until upd_done_i).
- R4: When pge_present_i is 0 at the accepted start, both global-page operations are left out of the entry phase and the global-page restore is left out of the exit phase. All other steps keep their order.
- R5: At most one request (or upd_go_o) is high at any time. A request stays high with stable attributes until its acknowledge is seen, and the next step's request rises in the cycle after that acknowledge.
- R6: The default-type write of the entry phase carries the saved value with bits 11:10 and 7:0 forced to 0 and all other bits unchanged.
- R7: After upd_done_i the exit operations run in this order: TLB flush, default-type write, control write with cr_cd_o=0, global-page write (if supported), lock release (lock_take_o=0).
- R8: The exit default-type write carries the saved copy. An upd_we_i seen while upd_go_o is high replaces that copy with upd_wdata_i. An upd_we_i seen at any other time has no effect.
- R9: The exit global-page write carries the value read at entry, and the entry global-page write carries 0.
- R10: irq_mask_o is high in every cycle in which busy_o is high, from the accepted start until the release completes.
- R11: done_o is a single-cycle pulse in the cycle after the release acknowledge, and busy_o is low in that same cycle.
- R12: A start_i that arrives while busy is ignored: after the run ends, no second run begins.
- R13: err_o is set when a request stays unacknowledged for TMO_CYC cycles. The sequence then continues once the acknowledge arrives, and err_o stays set until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only when idle |
| busy_o | output | 1 | A run is in progress |
| irq_mask_o | output | 1 | Interrupt mask request, high during a run |
| done_o | output | 1 | One-cycle pulse when a run has finished |
| err_o | output | 1 | Sticky acknowledge timeout flag |
| lock_req_o | output | 1 | Lock operation request |
| lock_take_o | output | 1 | 1 = acquire, 0 = release |
| lock_ack_i | input | 1 | Lock operation acknowledge |
| cr_req_o | output | 1 | Cache-control write request |
| cr_cd_o | output | 1 | Cache-disable value to write |
| cr_ack_i | input | 1 | Cache-control acknowledge |
| wb_req_o | output | 1 | Cache write-back and invalidate request |
| wb_ack_i | input | 1 | Write-back acknowledge |
| tlb_req_o | output | 1 | TLB flush request |
| tlb_ack_i | input | 1 | TLB flush acknowledge |
| pge_present_i | input | 1 | Global pages supported, sampled at start |
| pge_req_o | output | 1 | Global-page enable access request |
| pge_wr_o | output | 1 | 1 = write, 0 = read |
| pge_wdata_o | output | 1 | Global-page enable value to write |
| pge_rdata_i | input | 1 | Global-page enable read value |
| pge_ack_i | input | 1 | Global-page access acknowledge |
| dt_req_o | output | 1 | Default-type register access request |
| dt_wr_o | output | 1 | 1 = write, 0 = read |
| dt_wdata_o | output | DT_W | Default-type write value |
| dt_rdata_i | input | DT_W | Default-type read value |
| dt_ack_i | input | 1 | Default-type access acknowledge |
| upd_go_o | output | 1 | Updater may proceed |
| upd_done_i | input | 1 | Updater has finished |
| upd_we_i | input | 1 | Updater write to the saved default-type copy |
| upd_wdata_i | input | DT_W | New saved default-type value |

## Verification
A start seen at an edge shows up as busy_o and the lock request in the cycle after that edge. Every acknowledge or upd_done_i seen at an edge brings the next request in the following cycle, and done_o follows the release acknowledge by one cycle. err_o rises in the cycle after the TMO_CYC-th unanswered request cycle. The bench drives inputs and samples every output on the falling edge, so each observation lands mid-cycle after the register that produces it. Its responders log each operation and its write data at the moment they acknowledge, and the logs are compared against the step order and the field-clearing rule once the run ends.

// File: rtl/cache_reconfig_pkg.sv
package cache_reconfig_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LOCK, ST_CD_ON, ST_WB1, ST_PGE_RD, ST_PGE_CLR, ST_TLB1,
        ST_DT_RD, ST_DT_CLR, ST_WB2, ST_UPD, ST_TLB2, ST_DT_RST, ST_CD_OFF,
        ST_PGE_RST, ST_UNLOCK
    } step_e;

    typedef enum logic [2:0] {
        CH_NONE, CH_LOCK, CH_CR, CH_WB, CH_TLB, CH_PGE, CH_DT
    } chan_e;

    // flag: lock acquire / cache-disable value / write (for PGE and DT)
    typedef struct packed {
        chan_e chan;
        logic  flag;
    } op_t;

    // bits cleared in the default-type value on entry (enables and type)
    localparam logic [11:0] DT_CLR_FIELDS = 12'hCFF;

    function automatic op_t step_op(step_e s);
        op_t o;
        case (s)
            ST_LOCK:    o = '{CH_LOCK, 1'b1};
            ST_CD_ON:   o = '{CH_CR,   1'b1};
            ST_WB1,
            ST_WB2:     o = '{CH_WB,   1'b0};
            ST_PGE_RD:  o = '{CH_PGE,  1'b0};
            ST_PGE_CLR,
            ST_PGE_RST: o = '{CH_PGE,  1'b1};
            ST_TLB1,
            ST_TLB2:    o = '{CH_TLB,  1'b0};
            ST_DT_RD:   o = '{CH_DT,   1'b0};
            ST_DT_CLR,
            ST_DT_RST:  o = '{CH_DT,   1'b1};
            ST_CD_OFF:  o = '{CH_CR,   1'b0};
            ST_UNLOCK:  o = '{CH_LOCK, 1'b0};
            default:    o = '{CH_NONE, 1'b0};
        endcase
        return o;
    endfunction

    function automatic step_e step_next(step_e s, logic pge_en);
        step_e n;
        case (s)
            ST_LOCK:    n = ST_CD_ON;
            ST_CD_ON:   n = ST_WB1;
            ST_WB1:     n = pge_en ? ST_PGE_RD : ST_TLB1;
            ST_PGE_RD:  n = ST_PGE_CLR;
            ST_PGE_CLR: n = ST_TLB1;
            ST_TLB1:    n = ST_DT_RD;
            ST_DT_RD:   n = ST_DT_CLR;
            ST_DT_CLR:  n = ST_WB2;
            ST_WB2:     n = ST_UPD;
            ST_UPD:     n = ST_TLB2;
            ST_TLB2:    n = ST_DT_RST;
            ST_DT_RST:  n = ST_CD_OFF;
            ST_CD_OFF:  n = pge_en ? ST_PGE_RST : ST_UNLOCK;
            ST_PGE_RST: n = ST_UNLOCK;
            default:    n = ST_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/crs_fsm.sv
module crs_fsm
    import cache_reconfig_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  pge_present_i,
    input  logic  op_ack_i,
    input  logic  upd_done_i,
    output step_e step_o,
    output logic  start_acc_o,
    output logic  done_o
);
    step_e step_q;
    logic  pge_en_q;
    logic  advance;
    logic  busy;

    assign busy        = (step_q != ST_IDLE);
    assign start_acc_o = !busy && start_i;
    assign advance     = (step_q == ST_UPD) ? upd_done_i : (busy && op_ack_i);
    assign step_o      = step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q   <= ST_IDLE;
            pge_en_q <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            done_o <= (step_q == ST_UNLOCK) && op_ack_i;
            if (start_acc_o) begin
                step_q   <= ST_LOCK;
                pge_en_q <= pge_present_i;
            end else if (advance) begin
                step_q <= step_next(step_q, pge_en_q);
            end
        end
    end

    assert_start_gate_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_i));

    assert_no_restart_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i && step_q != ST_UNLOCK) |=> busy);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: rtl/crs_timer.sv
module crs_timer #(
    parameter int TMO_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic waiting_i,
    input  logic ack_i,
    output logic err_o
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            err_o <= 1'b0;
        end else begin
            if (clr_i)
                err_o <= 1'b0;
            if (!waiting_i || ack_i) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_MAX) begin
                err_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_err_from_wait_R13: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> $past(waiting_i && !ack_i));
endmodule

// File: rtl/crs_ctx.sv
module crs_ctx
    import cache_reconfig_pkg::*;
#(
    parameter int DT_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  step_e           step_i,
    input  logic            ack_i,
    input  logic            pge_rdata_i,
    input  logic [DT_W-1:0] dt_rdata_i,
    input  logic            upd_we_i,
    input  logic [DT_W-1:0] upd_wdata_i,
    output logic            saved_pge_o,
    output logic [DT_W-1:0] saved_dt_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            saved_pge_o <= 1'b0;
            saved_dt_o  <= '0;
        end else begin
            if (step_i == ST_PGE_RD && ack_i)
                saved_pge_o <= pge_rdata_i;
            if (step_i == ST_DT_RD && ack_i)
                saved_dt_o <= dt_rdata_i;
            else if (step_i == ST_UPD && upd_we_i)
                saved_dt_o <= upd_wdata_i;
        end
    end
endmodule

// File: rtl/cache_reconfig_seq.sv
module cache_reconfig_seq
    import cache_reconfig_pkg::*;
#(
    parameter int DT_W    = 64,
    parameter int TMO_CYC = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    output logic            busy_o,
    output logic            irq_mask_o,
    output logic            done_o,
    output logic            err_o,
    output logic            lock_req_o,
    output logic            lock_take_o,
    input  logic            lock_ack_i,
    output logic            cr_req_o,
    output logic            cr_cd_o,
    input  logic            cr_ack_i,
    output logic            wb_req_o,
    input  logic            wb_ack_i,
    output logic            tlb_req_o,
    input  logic            tlb_ack_i,
    input  logic            pge_present_i,
    output logic            pge_req_o,
    output logic            pge_wr_o,
    output logic            pge_wdata_o,
    input  logic            pge_rdata_i,
    input  logic            pge_ack_i,
    output logic            dt_req_o,
    output logic            dt_wr_o,
    output logic [DT_W-1:0] dt_wdata_o,
    input  logic [DT_W-1:0] dt_rdata_i,
    input  logic            dt_ack_i,
    output logic            upd_go_o,
    input  logic            upd_done_i,
    input  logic            upd_we_i,
    input  logic [DT_W-1:0] upd_wdata_i
);
    localparam logic [DT_W-1:0] CLR_MASK = DT_W'(DT_CLR_FIELDS);

    step_e           step;
    op_t             op;
    logic            op_ack;
    logic            start_acc;
    logic            saved_pge;
    logic [DT_W-1:0] saved_dt;

    assign op = step_op(step);

    always_comb begin
        case (op.chan)
            CH_LOCK: op_ack = lock_ack_i;
            CH_CR:   op_ack = cr_ack_i;
            CH_WB:   op_ack = wb_ack_i;
            CH_TLB:  op_ack = tlb_ack_i;
            CH_PGE:  op_ack = pge_ack_i;
            CH_DT:   op_ack = dt_ack_i;
            default: op_ack = 1'b0;
        endcase
    end

    crs_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .pge_present_i(pge_present_i),
        .op_ack_i     (op_ack),
        .upd_done_i   (upd_done_i),
        .step_o       (step),
        .start_acc_o  (start_acc),
        .done_o       (done_o)
    );

    crs_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (start_acc),
        .waiting_i(op.chan != CH_NONE),
        .ack_i    (op_ack),
        .err_o    (err_o)
    );

    crs_ctx #(.DT_W(DT_W)) u_ctx (
        .clk        (clk),
        .rst        (rst),
        .step_i     (step),
        .ack_i      (op_ack),
        .pge_rdata_i(pge_rdata_i),
        .dt_rdata_i (dt_rdata_i),
        .upd_we_i   (upd_we_i),
        .upd_wdata_i(upd_wdata_i),
        .saved_pge_o(saved_pge),
        .saved_dt_o (saved_dt)
    );

    assign busy_o      = (step != ST_IDLE);
    assign irq_mask_o  = busy_o;
    assign upd_go_o    = (step == ST_UPD);

    assign lock_req_o  = (op.chan == CH_LOCK);
    assign lock_take_o = lock_req_o && op.flag;
    assign cr_req_o    = (op.chan == CH_CR);
    assign cr_cd_o     = cr_req_o && op.flag;
    assign wb_req_o    = (op.chan == CH_WB);
    assign tlb_req_o   = (op.chan == CH_TLB);
    assign pge_req_o   = (op.chan == CH_PGE);
    assign pge_wr_o    = pge_req_o && op.flag;
    assign pge_wdata_o = (step == ST_PGE_RST) && saved_pge;
    assign dt_req_o    = (op.chan == CH_DT);
    assign dt_wr_o     = dt_req_o && op.flag;

    always_comb begin
        case (step)
            ST_DT_CLR: dt_wdata_o = saved_dt & ~CLR_MASK;
            ST_DT_RST: dt_wdata_o = saved_dt;
            default:   dt_wdata_o = '0;
        endcase
    end

    assert_one_op_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lock_req_o, cr_req_o, wb_req_o, tlb_req_o, pge_req_o, dt_req_o, upd_go_o}));

    assert_dt_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (dt_req_o && !dt_ack_i) |=> (dt_req_o && $stable(dt_wr_o) && $stable(dt_wdata_o)));

    assert_saved_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!upd_go_o && !dt_ack_i) |=> $stable(saved_dt));

    assert_end_with_done_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);
endmodule

// File: tb/cache_reconfig_seq_test.sv
module cache_reconfig_seq_test;
    localparam int DT_W = 64;
    localparam logic [63:0] JUNK = 64'h5555_AAAA_5555_AAAA;
    localparam int SEQ_P [15] = '{11,21,30,50,51,40,60,61,30,70,40,61,20,51,10};
    localparam int SEQ_N [12] = '{11,21,30,40,60,61,30,70,40,61,20,10};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic start_i = 1'b0, pge_present_i = 1'b0, pge_rdata_i = 1'b0;
    logic busy_o, irq_mask_o, done_o, err_o;
    logic lock_req_o, lock_take_o, cr_req_o, cr_cd_o, wb_req_o, tlb_req_o;
    logic pge_req_o, pge_wr_o, pge_wdata_o, dt_req_o, dt_wr_o, upd_go_o;
    logic [DT_W-1:0] dt_wdata_o;
    logic [DT_W-1:0] dt_rdata_i = '0;
    logic [DT_W-1:0] upd_wdata_i = '0;
    logic upd_done_i = 1'b0, upd_we_i = 1'b0;
    logic [5:0] acks = '0;
    logic [5:0] reqs;

    assign reqs = {dt_req_o, pge_req_o, tlb_req_o, wb_req_o, cr_req_o, lock_req_o};

    cache_reconfig_seq uut (
        .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
        .irq_mask_o(irq_mask_o), .done_o(done_o), .err_o(err_o),
        .lock_req_o(lock_req_o), .lock_take_o(lock_take_o), .lock_ack_i(acks[0]),
        .cr_req_o(cr_req_o), .cr_cd_o(cr_cd_o), .cr_ack_i(acks[1]),
        .wb_req_o(wb_req_o), .wb_ack_i(acks[2]),
        .tlb_req_o(tlb_req_o), .tlb_ack_i(acks[3]),
        .pge_present_i(pge_present_i), .pge_req_o(pge_req_o), .pge_wr_o(pge_wr_o),
        .pge_wdata_o(pge_wdata_o), .pge_rdata_i(pge_rdata_i), .pge_ack_i(acks[4]),
        .dt_req_o(dt_req_o), .dt_wr_o(dt_wr_o), .dt_wdata_o(dt_wdata_o),
        .dt_rdata_i(dt_rdata_i), .dt_ack_i(acks[5]),
        .upd_go_o(upd_go_o), .upd_done_i(upd_done_i),
        .upd_we_i(upd_we_i), .upd_wdata_i(upd_wdata_i)
    );

    int n_tests = 0, n_fail = 0;
    int dly [6] = '{1, 0, 2, 3, 1, 2};
    int cnt [6] = '{0, 0, 0, 0, 0, 0};
    logic [5:0] prev_req = '0;
    int log_code [32];
    int log_n = 0;
    logic [63:0] dtw [4];
    int ndw = 0;
    logic pgw [4];
    int npw = 0;
    int last_code = 0;
    int gap_bad = 0, drop_bad = 0;
    int ucnt = 0;
    bit upd_ovr = 0, upd_junk = 0, junk_on = 0;
    logic [63:0] ovr_val = '0;
    int cycles = 0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int op_code(int i);
        case (i)
            0: return 10 + int'(lock_take_o);
            1: return 20 + int'(cr_cd_o);
            2: return 30;
            3: return 40;
            4: return 50 + int'(pge_wr_o);
            default: return 60 + int'(dt_wr_o);
        endcase
    endfunction

    // responders for all operation ports and the updater
    always @(negedge clk) begin
        if (rst) begin
            acks <= '0;
            upd_done_i <= 1'b0;
            upd_we_i <= 1'b0;
        end else begin
            if (|acks && last_code != 10 && $countones({reqs, upd_go_o}) != 1)
                gap_bad++;
            for (int i = 0; i < 6; i++) begin
                if (acks[i]) begin
                    acks[i] <= 1'b0;
                    cnt[i] = 0;
                end else begin
                    if (prev_req[i] && !reqs[i]) drop_bad++;
                    if (reqs[i]) begin
                        if (cnt[i] >= dly[i]) begin
                            acks[i] <= 1'b1;
                            last_code = op_code(i);
                            if (log_n < 32) log_code[log_n] = last_code;
                            log_n++;
                            if (i == 5 && dt_wr_o && ndw < 4) begin dtw[ndw] = dt_wdata_o; ndw++; end
                            if (i == 4 && pge_wr_o && npw < 4) begin pgw[npw] = pge_wdata_o; npw++; end
                        end else begin
                            cnt[i]++;
                        end
                    end
                end
                prev_req[i] = reqs[i] && !acks[i];
            end
            if (upd_done_i) begin
                upd_done_i <= 1'b0;
                ucnt = 0;
                if (upd_junk) begin
                    junk_on = 1;
                    upd_we_i <= 1'b1;
                    upd_wdata_i <= JUNK;
                end
            end else if (junk_on) begin
                if (!busy_o) begin
                    junk_on = 0;
                    upd_we_i <= 1'b0;
                end
            end else if (upd_go_o) begin
                ucnt++;
                if (ucnt == 2 && upd_ovr) begin
                    upd_we_i <= 1'b1;
                    upd_wdata_i <= ovr_val;
                end else if (ucnt == 3) begin
                    upd_we_i <= 1'b0;
                    upd_done_i <= 1'b1;
                    last_code = 70;
                    if (log_n < 32) log_code[log_n] = 70;
                    log_n++;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", busy_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "idle outputs", {busy_o, irq_mask_o, done_o, err_o, upd_go_o, reqs}, 0);
    endtask

    task automatic run_seq(string name, bit pge, logic [63:0] dtrd, bit pgerd,
                           bit ovr, logic [63:0] ovv, bit junk, bit poke, bit exp_err);
        int irq_bad = 0;
        bit seen = 0, poked = 0;
        int split, mism_in = 0, mism_out = 0;
        logic [63:0] exp_rst;
        pge_present_i = pge; dt_rdata_i = dtrd; pge_rdata_i = pgerd;
        upd_ovr = ovr; ovr_val = ovv; upd_junk = junk;
        log_n = 0; ndw = 0; npw = 0; gap_bad = 0; drop_bad = 0; last_code = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2", {name, " busy/irq/lock acquire"},
            {busy_o, irq_mask_o, lock_req_o, lock_take_o}, 4'hF);
        chk("R13", {name, " err cleared on start"}, err_o, 0);
        for (int k = 0; k < 3000 && !seen; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (irq_mask_o !== busy_o) irq_bad++;
            if (done_o) begin
                seen = 1;
                chk("R11", {name, " busy low with done"}, busy_o, 0);
            end else if (poke && upd_go_o && !poked) begin
                start_i = 1'b1;
                poked = 1;
            end
        end
        chk("R11", {name, " done seen"}, seen, 1);
        @(negedge clk);
        chk("R11", {name, " done one cycle"}, done_o, 0);
        chk("R10", {name, " irq mask follows busy"}, irq_bad, 0);
        chk("R5", {name, " next request after ack"}, gap_bad, 0);
        chk("R5", {name, " request held to ack"}, drop_bad, 0);
        split = pge ? 9 : 7;
        chk(pge ? "R3" : "R4", {name, " op count"}, log_n, pge ? 15 : 12);
        for (int k = 0; k < log_n && k < 32; k++) begin
            int e;
            e = pge ? (k < 15 ? SEQ_P[k] : -1) : (k < 12 ? SEQ_N[k] : -1);
            if (log_code[k] != e) begin
                if (k <= split) mism_in++; else mism_out++;
            end
        end
        chk(pge ? "R3" : "R4", {name, " entry order"}, mism_in, 0);
        chk("R7", {name, " exit order"}, mism_out, 0);
        chk("R6", {name, " cleared default type"}, dtw[0], dtrd & ~64'hCFF);
        exp_rst = ovr ? ovv : dtrd;
        chk("R8", {name, " restored default type"}, dtw[1], exp_rst);
        if (pge) begin
            chk("R9", {name, " pge clear value"}, pgw[0], 0);
            chk("R9", {name, " pge restore value"}, pgw[1], pgerd);
        end
        chk("R13", {name, " err flag"}, err_o, exp_err);
        if (poke) begin
            int restarted = 0;
            repeat (6) begin
                @(negedge clk);
                if (busy_o) restarted++;
            end
            chk("R12", {name, " start while busy ignored"}, restarted, 0);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_basic();
        run_seq("basic", 1, 64'hFEDC_BA98_7654_3FFF, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_no_pge();
        dly = '{0, 2, 1, 0, 3, 4};
        run_seq("no_pge", 0, 64'h0000_0000_0000_0C06, 1, 0, 0, 0, 0, 0);
        dly = '{1, 0, 2, 3, 1, 2};
    endtask

    task automatic t_override();
        run_seq("override", 1, 64'h8000_0000_1234_5A5A, 0, 1, 64'h0000_0000_0000_0806, 1, 0, 0);
    endtask

    task automatic t_refuse();
        run_seq("refuse", 1, 64'h0000_0000_0000_0000, 1, 0, 0, 0, 1, 0);
    endtask

    task automatic t_timeout();
        dly[2] = 20;
        run_seq("timeout", 1, 64'h0000_00FF_FFFF_FFFF, 1, 0, 0, 0, 0, 1);
        dly[2] = 2;
        run_seq("after_timeout", 0, 64'h0000_0000_0000_0400, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_no_pge();
        t_override();
        t_refuse();
        t_timeout();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule